// File: doc/BRIEF.md
# Busy-Flagged Dynamic Clock Divider

This block divides an input clock by an integer selected through a small code field. The field lives inside a 16-bit control word that other dividers may share. Each write carries a per-field enable in its upper half, so one write can update this field and leave its neighbours untouched, or the reverse. A code does not give the divisor directly. It selects an entry of a parameter table, so codes can map to divisors that are not evenly spaced.

An accepted write does not change the output at once. It raises a busy flag in a status word. The new divisor takes over only at the end of the output period that is running when the write lands, so the switch never produces a short high or low pulse. The busy flag drops on the same input-clock edge that starts the first period at the new divisor. Software polls the flag until it is clear before each divisor write and again to confirm that the change is done. The flag position is a parameter, so several dividers can share one status word.

Top module: `dyn_clk_div`

## Requirements
- R1: While reset is held, the field code is 1 (divisor 2), the busy bit is 0 and `div_clk` is high.
- R2: The code field occupies `ctrl_wdata[6:4]`. It is written only when `ctrl_wdata[20]` (field bit position plus 16) is 1 in the same write. Without that bit the field and the busy bit keep their values. All other write bits have no effect on this divider. `ctrl_rdata` shows the code at bits [6:4] and zeros elsewhere.
- R3: An accepted write updates `ctrl_rdata` at the clock edge that samples it, and it sets the busy bit at that same edge.
- R4: A write that arrives while the busy bit is 1 is ignored: the field keeps its value.
- R5: The new divisor starts at the first output terminal count after the accepting edge. The busy bit returns to 0 on that same edge and not before.
- R6: Codes 0 to 7 select divisors 1, 2, 3, 4, 6, 8, 12 and 16.
- R7: For a divisor D of 2 or more, each output period starts high and stays high for ceil(D/2) input cycles, then stays low for the remaining cycles.
- R8: With divisor 1, `div_clk` follows the input clock.
- R9: The status word carries the busy bit at bit 2. Every other status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Write data: field values in [15:0], per-field enables in [31:16] |
| ctrl_rdata | output | 16 | Read-back of this divider's field within the control word |
| stat_rdata | output | 16 | Status word with the busy bit at its parameter position |
| div_clk | output | 1 | Divided output clock |

## Verification
The bench aims writes at every phase of the running period, including edges where the terminal count and the write coincide. A design that applied the divisor at once, or at the wrong terminal count, would show a short pulse or drop busy too early, and the reference model would catch the deviation at the next half cycle. A write issued while busy is still set checks that the field does not take the second code, which would otherwise silently retarget the pending update. The bench also counts high samples over a fixed window for every code, which exposes a wrong table entry, a duty cycle rounded the wrong way for odd divisors, and a divisor-1 bypass that fails to pass the input clock.

// File: rtl/dyn_div_pkg.sv
package dyn_div_pkg;

  // Number of high input cycles in one output period of divisor d (ceil(d/2)).
  function automatic logic [15:0] high_cycles(input logic [15:0] d);
    return (d >> 1) + {15'd0, d[0]};
  endfunction

  // True when the count value is the last cycle of a period of divisor d.
  function automatic logic at_terminal(input logic [15:0] count, input logic [15:0] d);
    return count == (d - 16'd1);
  endfunction

endpackage

// File: rtl/dyn_div_ctrl.sv
module dyn_div_ctrl #(
  parameter int FIELD_W  = 3,
  parameter int RST_CODE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               wen,
  input  logic [FIELD_W-1:0] wcode,
  input  logic               swap,
  output logic [FIELD_W-1:0] code_q,
  output logic               busy_q,
  output logic               accept
);

  // A write is taken only with its field enable set and no update pending.
  assign accept = wr & wen & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= FIELD_W'(RST_CODE);
      busy_q <= 1'b0;
    end else begin
      if (accept) begin
        code_q <= wcode;
        busy_q <= 1'b1;
      end else if (swap) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dyn_div_core.sv
module dyn_div_core
  import dyn_div_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic [DIV_W-1:0] new_div,
  output logic [DIV_W-1:0] act_div,
  output logic [DIV_W-1:0] cnt,
  output logic             phase_q,
  output logic             swap
);

  logic             tc;
  logic [DIV_W-1:0] cnt_nx;
  logic [DIV_W-1:0] div_nx;

  assign tc     = at_terminal(16'(cnt), 16'(act_div));
  assign swap   = tc & pending;
  assign cnt_nx = tc ? '0 : cnt + DIV_W'(1);
  assign div_nx = swap ? new_div : act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= DIV_W'(RST_DIV);
      cnt     <= '0;
      phase_q <= 1'b1;
    end else begin
      act_div <= div_nx;
      cnt     <= cnt_nx;
      phase_q <= 16'(cnt_nx) < high_cycles(16'(div_nx));
    end
  end

endmodule

// File: rtl/dyn_clk_div.sv
module dyn_clk_div #(
  parameter int FIELD_SHIFT = 4,
  parameter int FIELD_W     = 3,
  parameter int DIV_W       = 8,
  parameter int BUSY_POS    = 2,
  parameter int STAT_W      = 16,
  parameter int RST_CODE    = 1,
  parameter logic [(2**FIELD_W)*DIV_W-1:0] DIV_LUT =
    {8'd16, 8'd12, 8'd8, 8'd6, 8'd4, 8'd3, 8'd2, 8'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  output logic [15:0]       ctrl_rdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              div_clk
);

  localparam int NCODES  = 2 ** FIELD_W;
  localparam int WEN_BIT = FIELD_SHIFT + 16;
  localparam int RST_DIV = int'(DIV_LUT[RST_CODE*DIV_W +: DIV_W]);

  function automatic bit lut_has_unity();
    for (int i = 0; i < NCODES; i++) begin
      if (DIV_LUT[i*DIV_W +: DIV_W] == DIV_W'(1)) return 1'b1;
    end
    return 1'b0;
  endfunction

  localparam bit HAS_BYPASS = lut_has_unity();

  if (FIELD_SHIFT + FIELD_W > 16) begin : g_bad_field
    $error("divisor field does not fit in the low 16 bits");
  end

  logic [FIELD_W-1:0] code_q;
  logic               busy;
  logic               accept;
  logic               swap;
  logic [DIV_W-1:0]   new_div;
  logic [DIV_W-1:0]   act_div;
  logic [DIV_W-1:0]   cnt;
  logic               phase_q;
  logic               foreign_bits_unused;

  assign foreign_bits_unused = ^ctrl_wdata;

  dyn_div_ctrl #(
    .FIELD_W  (FIELD_W),
    .RST_CODE (RST_CODE)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctrl_wr),
    .wen    (ctrl_wdata[WEN_BIT]),
    .wcode  (ctrl_wdata[FIELD_SHIFT +: FIELD_W]),
    .swap   (swap),
    .code_q (code_q),
    .busy_q (busy),
    .accept (accept)
  );

  assign new_div = DIV_LUT[code_q*DIV_W +: DIV_W];

  dyn_div_core #(
    .DIV_W   (DIV_W),
    .RST_DIV (RST_DIV)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (busy),
    .new_div (new_div),
    .act_div (act_div),
    .cnt     (cnt),
    .phase_q (phase_q),
    .swap    (swap)
  );

  assign ctrl_rdata = 16'(code_q) << FIELD_SHIFT;
  assign stat_rdata = STAT_W'(busy) << BUSY_POS;

  if (HAS_BYPASS) begin : g_bypass
    assign div_clk = (act_div == DIV_W'(1)) ? clk : phase_q;
  end else begin : g_no_bypass
    assign div_clk = phase_q;
  end

endmodule

// File: rtl/dyn_div_chk.sv
module dyn_div_chk #(
  parameter int FIELD_SHIFT = 4,
  parameter int DIV_W       = 8,
  parameter int STAT_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              wen,
  input logic [15:0]       ctrl_rdata,
  input logic [STAT_W-1:0] stat_rdata,
  input logic              busy,
  input logic              accept,
  input logic              swap,
  input logic [DIV_W-1:0]  act_div,
  input logic [DIV_W-1:0]  cnt
);

  // R2: a write without the field enable leaves the field and busy alone
  a_r2_no_enable_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wen) |=> ($stable(ctrl_rdata) && $stable(busy)));

  // R3: an accepted write raises busy
  a_r3_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R4: a write while busy does not touch the field
  a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> $stable(ctrl_rdata));

  // R5: busy holds until the swap edge
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !swap) |=> busy);

  // R5: the swap edge clears busy and starts a fresh period
  a_r5_swap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (!busy && cnt == '0));

  // R5: the running divisor moves only on a swap
  a_r5_div_only_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(act_div));

  // R9: at most one status bit is ever set
  a_r9_status_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_rdata));

endmodule

bind dyn_clk_div dyn_div_chk #(
  .FIELD_SHIFT (FIELD_SHIFT),
  .DIV_W       (DIV_W),
  .STAT_W      (STAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr         (ctrl_wr),
  .wen        (ctrl_wdata[FIELD_SHIFT+16]),
  .ctrl_rdata (ctrl_rdata),
  .stat_rdata (stat_rdata),
  .busy       (busy),
  .accept     (accept),
  .swap       (swap),
  .act_div    (act_div),
  .cnt        (cnt)
);

// File: tb/test_dyn_clk_div.sv
`timescale 1ns/1ps
module test_dyn_clk_div;

  localparam int SH  = 4;
  localparam int WEN = 20;
  localparam int BP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  wire  [15:0] ctrl_rdata;
  wire  [15:0] stat_rdata;
  wire         div_clk;

  always #2 clk = ~clk;

  dyn_clk_div i_dyn_clk_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .stat_rdata (stat_rdata),
    .div_clk    (div_clk)
  );

  int tab [8] = '{1, 2, 3, 4, 6, 8, 12, 16};

  int m_code, m_div, m_cnt;
  bit m_busy;
  bit m_live = 1'b0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin : ref_model
    bit tc, acc;
    if (!rst_n) begin
      m_code = 1; m_div = 2; m_cnt = 0; m_busy = 1'b0; m_live = 1'b0;
    end else begin
      acc = ctrl_wr && ctrl_wdata[WEN] && !m_busy;
      tc  = (m_cnt == m_div - 1);
      if (tc) begin
        m_cnt = 0;
        if (m_busy) begin
          m_div  = tab[m_code];
          m_busy = 1'b0;
        end
      end else begin
        m_cnt++;
      end
      if (acc) begin
        m_code = int'((ctrl_wdata >> SH) & 32'd7);
        m_busy = 1'b1;
      end
      m_live = 1'b1;
    end
  end

  task automatic compare(input bit lvl);
    int exp;
    exp = (m_div == 1) ? int'(lvl) : int'(m_cnt < (m_div + 1) / 2);
    check(int'(div_clk) == exp, (m_div == 1) ? "R8" : "R7", "div_clk", int'(div_clk), exp);
    check(int'(ctrl_rdata) == (m_code << SH), "R2", "ctrl_rdata", int'(ctrl_rdata), m_code << SH);
    check(stat_rdata[BP] == m_busy, "R5", "busy", int'(stat_rdata[BP]), int'(m_busy));
    check((stat_rdata & ~16'(1 << BP)) == 16'd0, "R9", "spare status bits",
          int'(stat_rdata & ~16'(1 << BP)), 0);
  endtask

  always @(posedge clk) begin
    #1;
    if (m_live && !done) compare(1'b1);
  end

  always @(negedge clk) begin
    if (m_live && !done) compare(1'b0);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    do begin
      @(posedge clk); #1;
      guard++;
    end while (stat_rdata[BP] && guard < 100);
    check(!stat_rdata[BP], "R5", "busy cleared within bound", int'(stat_rdata[BP]), 0);
  endtask

  // called at the first sample of a fresh period
  task automatic measure(input int code);
    int d, hi;
    d  = tab[code];
    hi = int'(div_clk);
    for (int i = 1; i < 48; i++) begin
      @(posedge clk); #1;
      hi += int'(div_clk);
    end
    check(hi == (48 / d) * ((d + 1) / 2), "R6", "high samples per 48 cycles",
          hi, (48 / d) * ((d + 1) / 2));
  endtask

  task automatic run_code(input int code);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = (32'(code) << SH) | (32'd1 << WEN);
    @(negedge clk);
    ctrl_wr = 1'b0;
    ctrl_wdata = '0;
    check(stat_rdata[BP] == 1'b1, "R3", "busy after accept", int'(stat_rdata[BP]), 1);
    check(int'(ctrl_rdata) == (code << SH), "R3", "field after accept",
          int'(ctrl_rdata), code << SH);
    wait_idle();
    measure(code);
  endtask

  initial begin
    int codes [8] = '{3, 0, 7, 5, 1, 2, 4, 6};
    repeat (3) @(posedge clk);
    #1;
    check(div_clk == 1'b1, "R1", "div_clk in reset", int'(div_clk), 1);
    check(ctrl_rdata == 16'h0010, "R1", "field in reset", int'(ctrl_rdata), 16'h10);
    check(stat_rdata == 16'h0000, "R1", "status in reset", int'(stat_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    foreach (codes[k]) run_code(codes[k]);

    // R4: second write lands while the first is still pending
    run_code(7);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = (32'd2 << SH) | (32'd1 << WEN);
    @(negedge clk);
    ctrl_wdata = (32'd5 << SH) | (32'd1 << WEN);
    @(negedge clk);
    ctrl_wr = 1'b0;
    ctrl_wdata = '0;
    check(int'(ctrl_rdata) == (2 << SH), "R4", "field after busy write", int'(ctrl_rdata), 2 << SH);
    wait_idle();
    check(int'(ctrl_rdata) == (2 << SH), "R4", "field after settle", int'(ctrl_rdata), 2 << SH);
    measure(2);

    // R2: field bits set but enable clear
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = 32'h00EF_FFFF;
    @(negedge clk);
    ctrl_wr = 1'b0;
    ctrl_wdata = '0;
    check(int'(ctrl_rdata) == (2 << SH), "R2", "field without enable", int'(ctrl_rdata), 2 << SH);
    check(stat_rdata[BP] == 1'b0, "R2", "busy without enable", int'(stat_rdata[BP]), 0);
    repeat (6) @(negedge clk);
    check(int'(ctrl_rdata) == (2 << SH), "R2", "field later", int'(ctrl_rdata), 2 << SH);

    // R2: enable set, neighbouring bits all set
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = 32'hFFFF_FFCF;
    @(negedge clk);
    ctrl_wr = 1'b0;
    ctrl_wdata = '0;
    check(int'(ctrl_rdata) == (4 << SH), "R2", "field with neighbours set", int'(ctrl_rdata), 4 << SH);
    wait_idle();
    measure(4);

    // quick transitions through divisor 1
    run_code(0);
    run_code(7);
    run_code(0);
    run_code(3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule